// File: doc/BRIEF.md
# Fixed-Frame Pulse-Width Generator

This block turns a slow tick stream into a pulse-width modulated level. Each frame is `period + 1` ticks long. The output is high for the first `on` ticks of the frame and low for the rest. The tick stream comes from an external variable-frequency source. It arrives as a one-cycle enable on the system clock, so the counter runs only on cycles where that enable is asserted. The duty ratio is `on / (period + 1)`.

Software writes the on and period values into input ports that act as shadow registers. The active copies reload only at a frame wrap, so a frame that is already running is never cut short or stretched. While the channel is stopped, the active copies track the shadow values on every cycle. The counter is held at zero and the output is held low.

There is no separate mode for 100% duty. Any on count larger than the period value gives a constant-high level; on = 255 with period = 254 is the usual setting. An on count of 0 gives a constant-low level. A period value of 0 is not a valid setting.

Top module: `pwm_frame_gen`

## Requirements
- R1: After a synchronous active-low reset, the output is low, the frame counter is zero and both active values are zero.
- R2: While running, the frame counter advances by one only on cycles with `tick_en` high. It returns to zero on the tick after it equals the active period value, so one frame lasts `period + 1` ticks.
- R3: While running, the output is high exactly when the frame position (0 at the start of a frame) is below the active on count. The output is registered and shows the position reached at the latest clock edge.
- R4: When the active on count is greater than the active period value, the output stays high for as long as the channel runs (for example on = 255, period = 254).
- R5: An active on count of 0 keeps the output low.
- R6: While running, changes on `on_cnt` and `period_cnt` have no effect until the counter wraps to zero. At that tick both values are loaded together.
- R7: With `run` low, the next clock edge clears the counter, drives the output low and loads the on and period inputs into the active values, so a restart begins a fresh frame with them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle tick from the variable-frequency source |
| run | input | 1 | Channel start control; low stops and clears the channel |
| on_cnt | input | W (8) | Shadow on count, in ticks |
| period_cnt | input | W (8) | Shadow period value; the frame is this plus one ticks |
| pwm_out | output | 1 | Registered pulse-width modulated level |

## Verification
The bench builds the block with the default width of 8. This makes the extreme register values reachable, including on = 255 against period = 254 and the full 255-tick frame. Tick enables are driven continuously and at one tick every third cycle, which shows that the counter holds between ticks. The shadow values are rewritten in the middle of a frame and while the channel is stopped. Every output cycle is compared against a position model, so a reload that happens early or late, or a frame that is one tick off, shows up as a mismatch.

// File: rtl/pwm_frame_pkg.sv
// Shared definitions for the fixed-frame pulse-width generator.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_frame_pkg;

    // Why the active on/period copies are loaded on a given cycle.
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,   // keep the active values
        LD_STOP = 2'd1,   // channel stopped: follow the shadow inputs
        LD_WRAP = 2'd2    // frame wrapped: take the shadow inputs
    } load_cause_e;

endpackage

// File: rtl/pwm_frame_counter.sv
// Frame position counter.
// Counts ticks from 0 up to the active period value and then wraps to 0.
// Assumes: tick_en is a one-cycle strobe; run low clears the count.
// Exposes the next count so that the output stage can register a level
// that matches the count after the edge.
module pwm_frame_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick_en,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONE  = {{(W-1){1'b0}}, 1'b1};

    // Frame end: a tick arrives while the count sits on the period value.
    always_comb begin
        wrap = run && tick_en && (cnt_q == per_act);
    end

    // Next count: clear when stopped, wrap at frame end, else step on tick.
    always_comb begin
        if (!run)
            cnt_nxt = CNT_ZERO;
        else if (wrap)
            cnt_nxt = CNT_ZERO;
        else if (tick_en)
            cnt_nxt = cnt_q + CNT_ONE;
        else
            cnt_nxt = cnt_q;
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_ZERO;
        else
            cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/pwm_shadow_regs.sv
// Active on/period values, double-buffered behind the shadow inputs.
// Loads both values together at a frame wrap, or on every cycle while the
// channel is stopped. The counter and the compare stage never see a
// half-updated pair.
// Assumes: the shadow inputs are held stable by the register block.
module pwm_shadow_regs
    import pwm_frame_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wrap,
    input  logic [W-1:0] on_sh,
    input  logic [W-1:0] per_sh,
    output logic [W-1:0] on_act,
    output logic [W-1:0] per_act,
    output logic [W-1:0] on_nxt
);
    load_cause_e  cause;
    logic [W-1:0] per_nxt;

    // Decide whether and why the active pair reloads this cycle.
    always_comb begin
        if (!run)
            cause = LD_STOP;
        else if (wrap)
            cause = LD_WRAP;
        else
            cause = LD_NONE;
    end

    // Next active pair: the shadow values on any load, else unchanged.
    always_comb begin
        unique case (cause)
            LD_STOP, LD_WRAP: begin
                on_nxt  = on_sh;
                per_nxt = per_sh;
            end
            default: begin
                on_nxt  = on_act;
                per_nxt = per_act;
            end
        endcase
    end

    // Active pair registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_act  <= '0;
            per_act <= '0;
        end else begin
            on_act  <= on_nxt;
            per_act <= per_nxt;
        end
    end
endmodule

// File: rtl/pwm_level_out.sv
// Output stage: registers the level that matches the count after the edge.
// The level is high while running and the next position is below the next
// on count. On counts above the period therefore give a constant high, and
// an on count of zero gives a constant low. Driving the pin from a flop
// keeps comparator hazards off the output.
// Assumes: cnt_nxt and on_nxt come from the same cycle's next-state logic.
module pwm_level_out #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] on_nxt,
    output logic         level_q
);
    logic level_nxt;

    // Compare the next position against the next on count.
    always_comb begin
        level_nxt = run && (cnt_nxt < on_nxt);
    end

    // Output flop with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= 1'b0;
        else
            level_q <= level_nxt;
    end
endmodule

// File: rtl/pwm_frame_gen.sv
// Fixed-frame pulse-width generator top.
// Each frame is period+1 ticks long, and the output is high for the first
// `on` ticks of it. The shadow inputs reach the active pair only at a frame
// wrap or while the channel is stopped.
// Assumes: tick_en comes from a variable-frequency tick source in the clk
// domain; a period value of 0 is not a valid setting.
module pwm_frame_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         run,
    input  logic [W-1:0] on_cnt,
    input  logic [W-1:0] period_cnt,
    output logic         pwm_out
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;
    logic         wrap;
    logic [W-1:0] on_act;
    logic [W-1:0] per_act;
    logic [W-1:0] on_nxt;

    pwm_frame_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick_en (tick_en),
        .per_act (per_act),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    pwm_shadow_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .wrap    (wrap),
        .on_sh   (on_cnt),
        .per_sh  (period_cnt),
        .on_act  (on_act),
        .per_act (per_act),
        .on_nxt  (on_nxt)
    );

    pwm_level_out #(.W(W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .cnt_nxt (cnt_nxt),
        .on_nxt  (on_nxt),
        .level_q (pwm_out)
    );
endmodule

// File: rtl/pwm_frame_gen_chk.sv
// Property checker for pwm_frame_gen, attached with bind.
// Observes the ports and the counter and active-value registers.
module pwm_frame_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic         run,
    input logic [W-1:0] cnt,
    input logic [W-1:0] on_act,
    input logic [W-1:0] per_act,
    input logic         pwm_out
);
    logic run_d;

    // Remember whether the channel ran at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_d <= 1'b0;
        else
            run_d <= run;
    end

    // R2: without a tick the count holds.
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick_en |=> $stable(cnt));

    // R2: the count never passes the active period value.
    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_act);

    // R4: an on count above the period keeps the output high while running.
    a_r4_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        run_d && (on_act > per_act) |-> pwm_out);

    // R5: an on count of zero keeps the output low.
    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (on_act == '0) |-> !pwm_out);

    // R6: the on count is held except at a wrap while running.
    a_r6_hold_on: assert property (@(posedge clk) disable iff (!rst_n)
        run && !(tick_en && cnt == per_act) |=> $stable(on_act));

    // R7: stopping clears the counter and drives the output low.
    a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0) && !pwm_out);
endmodule

bind pwm_frame_gen pwm_frame_gen_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .run     (run),
    .cnt     (cnt_q),
    .on_act  (on_act),
    .per_act (per_act),
    .pwm_out (pwm_out)
);

// File: tb/pwm_frame_gen_tb.sv
// Scoreboard bench: the driver task models the frame position and pushes
// the expected level for each cycle; the monitor pops and compares.
module pwm_frame_gen_tb;
    localparam int W = 8;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         run = 1'b0;
    logic [W-1:0] on_cnt = '0;
    logic [W-1:0] period_cnt = '0;
    logic         pwm_out;

    int    checks = 0;
    int    errors = 0;
    item_t sb_q[$];
    string cur_tag = "R1";

    // Bench model of the frame state
    int m_pos = 0;
    int m_on  = 0;
    int m_per = 0;

    pwm_frame_gen #(.W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .run        (run),
        .on_cnt     (on_cnt),
        .period_cnt (period_cnt),
        .pwm_out    (pwm_out)
    );

    always #10 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pwm_out=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one clock cycle with the given tick, then push the expected level.
    task automatic step(input logic tick);
        @(negedge clk);
        tick_en = tick;
        @(posedge clk);
        if (!run) begin
            m_pos = 0;
            m_on  = int'(on_cnt);
            m_per = int'(period_cnt);
        end else if (tick) begin
            if (m_pos == m_per) begin
                m_pos = 0;
                m_on  = int'(on_cnt);
                m_per = int'(period_cnt);
            end else begin
                m_pos++;
            end
        end
        #1;
        sb_q.push_back('{exp: (run && (m_pos < m_on)), tag: cur_tag});
    endtask

    task automatic steps(input int n, input int tick_every);
        for (int i = 0; i < n; i++)
            step((i % tick_every) == 0);
    endtask

    // Monitor: compare one expected item per cycle, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(pwm_out, it.exp, it.tag);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pwm_out, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out, 1'b0, "R1 after reset");

        // R7: stopped, values load immediately, output low
        cur_tag = "R7 stopped";
        on_cnt = 8'd3; period_cnt = 8'd7;
        steps(3, 1);

        // R3: basic duty with a tick every cycle
        cur_tag = "R3 on=3 period=7";
        run = 1'b1;
        steps(20, 1);

        // R2: tick every third cycle, counter holds between ticks
        cur_tag = "R2 sparse ticks";
        steps(40, 3);

        // R6: mid-frame rewrite takes effect only at the wrap
        cur_tag = "R6 mid-frame update";
        on_cnt = 8'd6; period_cnt = 8'd9;
        steps(30, 1);

        // R4: on above period gives a constant high over full 255-tick frames
        cur_tag = "R4 on=255 period=254";
        on_cnt = 8'd255; period_cnt = 8'd254;
        steps(600, 1);

        // R7: stop in mid-frame, then R5 with a zero on count
        cur_tag = "R7 stop mid-frame";
        steps(5, 1);
        run = 1'b0;
        on_cnt = 8'd0; period_cnt = 8'd4;
        steps(3, 1);
        cur_tag = "R5 on=0";
        run = 1'b1;
        steps(25, 1);

        // R3: smallest valid frame, restart after stop
        cur_tag = "R7 restart";
        run = 1'b0;
        on_cnt = 8'd1; period_cnt = 8'd1;
        steps(2, 1);
        cur_tag = "R3 on=1 period=1";
        run = 1'b1;
        steps(12, 1);
        cur_tag = "R2 on=1 period=1 sparse";
        steps(12, 2);

        // R6: rewrite the shadow inputs while ticks are paused, mid-frame
        cur_tag = "R6 paused update";
        on_cnt = 8'd2; period_cnt = 8'd5;
        steps(6, 4);
        steps(20, 1);

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule